// File: doc/BRIEF.md
# Configurable Interrupt Pin Controller

The block merges three interrupt events into one interrupt pin: a watchdog timeout, an alarm match and a power-fail event. Each event arrives as a single-cycle pulse. Each source has its own enable bit, and a source whose enable is clear does not reach the pin. The flags these events set are kept outside the block. A byte-wide configuration register holds the three enables and two mode bits.

The first mode bit selects the electrical style of the pin:
- **Push-pull, active high:** the output enable is held on and the data value equals the active state.
- **Open drain, active low:** the pin is driven to 0 only while it is active and is released otherwise.

The second mode bit selects how long the pin stays active:
- **Pulse mode:** the pin stays active for 200 millisecond ticks after the most recent enabled event.
- **Level mode:** the pin stays active until the external flags register is read, which the block sees as a read strobe.

A state machine with three states makes the decision:
- `ST_IDLE`: the pin is inactive.
- `ST_PULSE`: a timed pulse is running.
- `ST_LEVEL`: the pin is held until a flags read.

It has these transitions:
- `IDLE->PULSE`: an enabled event in pulse mode.
- `IDLE->LEVEL`: an enabled event in level mode.
- `PULSE->PULSE reload`: any enabled event while a pulse runs.
- `PULSE->IDLE`: the tick that ends the count.
- `LEVEL->IDLE`: a flags read with no enabled event in the same cycle.

A mode change while the pin is active takes effect only after the machine returns to idle.

Top module: `intpin_ctrl`

## Requirements
- R1: The configuration register resets to 0x00. A write stores bit 7 (watchdog enable), bit 6 (alarm enable), bit 5 (power-fail enable), bit 3 (high/low select, 1 = push-pull active high) and bit 2 (pulse/level select, 1 = pulse). Bits 4, 1 and 0 always read 0, so writing 0xFF reads back 0xEC.
- R2: An event whose enable bit is 0 leaves the pin inactive.
- R3: An event from any one of the three sources with its enable set makes the pin active in the cycle after the clock edge that samples it.
- R4: With high/low = 1, the output enable is 1 at all times and the data value is 1 exactly while the pin is active.
- R5: With high/low = 0, the output enable is 1 and the data value is 0 while the pin is active, and the output enable is 0 while the pin is inactive.
- R6: In pulse mode, the pin stays active through 199 millisecond ticks after an enabled event and goes inactive with the 200th tick.
- R7: In pulse mode, an enabled event during an active pulse restarts the count, so 200 further ticks are needed before the pin goes inactive.
- R8: In level mode, the pin stays active, whatever the ticks do, until a flags-read strobe. It goes inactive in the cycle after the strobe.
- R9: In level mode, an enabled event in the same cycle as a flags-read strobe keeps the pin active.
- R10: After reset, the pin is inactive: the output enable is 0 and the data value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data, with reserved bits at 0 |
| wdog_evt | input | 1 | Watchdog timeout event pulse |
| alarm_evt | input | 1 | Alarm match event pulse |
| pfail_evt | input | 1 | Power-fail event pulse |
| flags_rd | input | 1 | Strobe marking a read of the external flags register |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| pin_out | output | 1 | Interrupt pin data value |
| pin_oe | output | 1 | Interrupt pin output enable |

## Verification
Two pairs of functions can fall in the same clock cycle.

The first pair is a flags-read strobe and a new enabled event in level mode. The bench raises `flags_rd` and `alarm_evt` on the same falling edge. The pin must still be active one cycle later, and a later lone strobe must release it.

The second pair is the tick that would end a pulse and a reloading event. The bench issues 150 ticks, then an event, then exactly 199 more ticks, and checks that the pin stays active until the 200th tick after the reload.

// File: rtl/intpin_pkg.sv
package intpin_pkg;

    localparam int NSRC = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_LEVEL = 2'd2
    } pin_state_t;

    typedef struct packed {
        logic [NSRC-1:0] en;   // [2] watchdog, [1] alarm, [0] power fail
        logic            hl;   // 1: push-pull active high
        logic            pl;   // 1: timed pulse
    } pin_cfg_t;

endpackage

// File: rtl/intpin_cfg_reg.sv
module intpin_cfg_reg
    import intpin_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output pin_cfg_t   cfg
);

    pin_cfg_t cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr) begin
            cfg_q.en <= wdata[7:5];
            cfg_q.hl <= wdata[3];
            cfg_q.pl <= wdata[2];
        end
    end

    always_comb begin
        rdata      = 8'h00;
        rdata[7:5] = cfg_q.en;
        rdata[3]   = cfg_q.hl;
        rdata[2]   = cfg_q.pl;
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/intpin_src_gate.sv
module intpin_src_gate
    import intpin_pkg::*;
(
    input  logic [NSRC-1:0] evt,
    input  logic [NSRC-1:0] en,
    output logic            hit
);

    logic [NSRC-1:0] gated;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign gated[i] = evt[i] & en[i];
    end

    assign hit = |gated;

endmodule

// File: rtl/intpin_fsm.sv
module intpin_fsm
    import intpin_pkg::*;
#(
    parameter int PULSE_MS = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit,
    input  logic       pulse_mode,
    input  logic       flags_rd,
    input  logic       ms_tick,
    output pin_state_t state_o,
    output logic       active_o
);

    localparam int CNT_W = $clog2(PULSE_MS + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_MS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    pin_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // next-state and count decision
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (hit && pulse_mode) begin
                    state_d = ST_PULSE;
                    cnt_d   = CNT_LOAD;
                end else if (hit) begin
                    state_d = ST_LEVEL;
                end
            end
            ST_PULSE: begin
                if (hit) begin
                    cnt_d = CNT_LOAD;
                end else if (ms_tick) begin
                    if (cnt_q <= CNT_LAST) begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q - CNT_LAST;
                    end
                end
            end
            ST_LEVEL: begin
                if (flags_rd && !hit) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        state_o = state_q;
        unique case (state_q)
            ST_PULSE, ST_LEVEL: active_o = 1'b1;
            default:            active_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/intpin_drive.sv
module intpin_drive (
    input  logic active,
    input  logic push_pull,
    output logic pin_out,
    output logic pin_oe
);

    always_comb begin
        if (push_pull) begin
            pin_oe  = 1'b1;
            pin_out = active;
        end else begin
            pin_oe  = active;
            pin_out = 1'b0;
        end
    end

endmodule

// File: rtl/intpin_ctrl.sv
module intpin_ctrl
    import intpin_pkg::*;
#(
    parameter int PULSE_MS = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    input  logic       wdog_evt,
    input  logic       alarm_evt,
    input  logic       pfail_evt,
    input  logic       flags_rd,
    input  logic       ms_tick,
    output logic       pin_out,
    output logic       pin_oe
);

    pin_cfg_t   cfg;
    logic       hit;
    logic       active;
    pin_state_t state;

    intpin_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg)
    );

    intpin_src_gate u_gate (
        .evt ({wdog_evt, alarm_evt, pfail_evt}),
        .en  (cfg.en),
        .hit (hit)
    );

    intpin_fsm #(.PULSE_MS(PULSE_MS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .pulse_mode (cfg.pl),
        .flags_rd   (flags_rd),
        .ms_tick    (ms_tick),
        .state_o    (state),
        .active_o   (active)
    );

    intpin_drive u_drv (
        .active    (active),
        .push_pull (cfg.hl),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

endmodule

// File: rtl/intpin_ctrl_chk.sv
module intpin_ctrl_chk
    import intpin_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] cfg_rdata,
    input logic       flags_rd,
    input logic       ms_tick,
    input logic       hit,
    input pin_state_t state,
    input logic       pin_out,
    input logic       pin_oe
);

    logic pin_act;
    assign pin_act = cfg_rdata[3] ? pin_out : (pin_oe && !pin_out);

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[4] == 1'b0) && (cfg_rdata[1:0] == 2'b00)); // R1

    AST_QUIET_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_act && !hit) |=> !pin_act); // R2

    AST_HIT_ACTIVATES: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (state != ST_IDLE)); // R3

    AST_PP_OE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[3] |-> pin_oe); // R4

    AST_OD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rdata[3] && state == ST_IDLE) |-> (!pin_oe && !pin_out)); // R5

    AST_PULSE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULSE && !ms_tick) |=> (state == ST_PULSE)); // R6

    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LEVEL && !flags_rd) |=> (state == ST_LEVEL)); // R8

    AST_RD_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LEVEL && flags_rd && hit) |=> (state == ST_LEVEL)); // R9

endmodule

bind intpin_ctrl intpin_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_rdata (cfg_rdata),
    .flags_rd  (flags_rd),
    .ms_tick   (ms_tick),
    .hit       (hit),
    .state     (state),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/tb_intpin_ctrl.sv
`timescale 1ns/1ps
module tb_intpin_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       wdog_evt = 1'b0, alarm_evt = 1'b0, pfail_evt = 1'b0;
    logic       flags_rd = 1'b0, ms_tick = 1'b0;
    logic       pin_out, pin_oe;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    intpin_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .wdog_evt(wdog_evt), .alarm_evt(alarm_evt),
        .pfail_evt(pfail_evt), .flags_rd(flags_rd), .ms_tick(ms_tick),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // config bit values
    localparam logic [7:0] EN_W = 8'h80, EN_A = 8'h40, EN_P = 8'h20;
    localparam logic [7:0] HL = 8'h08, PL = 8'h04;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic pin_active(input logic hl);
        return hl ? pin_out : (pin_oe && !pin_out);
    endfunction

    task automatic wr_cfg(input logic [7:0] d);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = d;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    // 0: watchdog, 1: alarm, 2: power fail
    task automatic fire(input int src);
        @(negedge clk);
        wdog_evt = (src == 0); alarm_evt = (src == 1); pfail_evt = (src == 2);
        @(negedge clk);
        wdog_evt = 1'b0; alarm_evt = 1'b0; pfail_evt = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ms_tick = 1'b1;
            @(negedge clk); ms_tick = 1'b0;
        end
    endtask

    task automatic rd_flags();
        @(negedge clk); flags_rd = 1'b1;
        @(negedge clk); flags_rd = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R10 oe", {7'b0, pin_oe}, 8'h00);
        chk("R10 out", {7'b0, pin_out}, 8'h00);
        chk("R1 reset value", cfg_rdata, 8'h00);
    endtask

    task automatic t_reg();
        wr_cfg(8'hFF);
        chk("R1 reserved bits", cfg_rdata, 8'hEC);
        wr_cfg(8'h44);
        chk("R1 readback", cfg_rdata, 8'h44);
        wr_cfg(8'h00);
    endtask

    task automatic t_disabled();
        wr_cfg(HL | PL | EN_A | EN_P);
        fire(0);
        chk("R2 watchdog disabled", {7'b0, pin_active(1'b1)}, 8'h00);
        wr_cfg(HL | EN_W);
        fire(1);
        fire(2);
        chk("R2 alarm/pfail disabled", {7'b0, pin_active(1'b1)}, 8'h00);
    endtask

    task automatic t_sources();
        for (int s = 0; s < 3; s++) begin
            wr_cfg(HL | EN_W | EN_A | EN_P);
            fire(s);
            chk("R3 source activates", {7'b0, pin_active(1'b1)}, 8'h01);
            rd_flags();
            chk("R8 released by read", {7'b0, pin_active(1'b1)}, 8'h00);
        end
    endtask

    task automatic t_drive();
        wr_cfg(HL | EN_A);
        chk("R4 idle oe", {6'b0, pin_oe, pin_out}, 8'h02);
        fire(1);
        chk("R4 active", {6'b0, pin_oe, pin_out}, 8'h03);
        rd_flags();
        wr_cfg(EN_A);
        chk("R5 idle released", {6'b0, pin_oe, pin_out}, 8'h00);
        fire(1);
        chk("R5 active low", {6'b0, pin_oe, pin_out}, 8'h02);
        rd_flags();
        chk("R5 released", {6'b0, pin_oe, pin_out}, 8'h00);
    endtask

    task automatic t_pulse();
        wr_cfg(HL | PL | EN_P);
        fire(2);
        ticks(199);
        chk("R6 after 199 ticks", {7'b0, pin_active(1'b1)}, 8'h01);
        ticks(1);
        chk("R6 after 200 ticks", {7'b0, pin_active(1'b1)}, 8'h00);
    endtask

    task automatic t_restart();
        wr_cfg(PL | EN_W);
        fire(0);
        ticks(150);
        fire(0);
        ticks(199);
        chk("R7 reload holds", {7'b0, pin_active(1'b0)}, 8'h01);
        ticks(1);
        chk("R7 ends after reload", {7'b0, pin_active(1'b0)}, 8'h00);
    endtask

    task automatic t_level();
        wr_cfg(HL | EN_A);
        fire(1);
        ticks(250);
        chk("R8 holds through ticks", {7'b0, pin_active(1'b1)}, 8'h01);
        @(negedge clk); flags_rd = 1'b1; alarm_evt = 1'b1;
        @(negedge clk); flags_rd = 1'b0; alarm_evt = 1'b0;
        chk("R9 event beats read", {7'b0, pin_active(1'b1)}, 8'h01);
        rd_flags();
        chk("R8 lone read releases", {7'b0, pin_active(1'b1)}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_reg();
        t_disabled();
        t_sources();
        t_drive();
        t_pulse();
        t_restart();
        t_level();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule